// File: doc/BRIEF.md
# Divider Configuration Loader with Serial and Parallel Paths

This block holds the setup word of a clock synthesizer: a 9-bit feedback divider value, a 2-bit output divider code and a 3-bit test select. Two independent routes can load that word. A three-wire serial route shifts bits into a 14-bit register and commits them with a load strobe. A parallel route copies divider pins while its own strobe is low.

The parallel route always wins. While its strobe is low, the divider outputs track the pins and the test select is held at zero. A typical system keeps the parallel strobe low after power-up and raises it once to fix a default frequency. Software-like control can then retune the part over the serial wires. All external controls are asynchronous. Each one passes through a multi-flop synchronizer into the fast system clock, and edges are detected there. The block also raises a flag whenever the held feedback divider lies outside the usable window of 200 to 400.

Top module: `synth_cfg_loader`

## Requirements
- R1: On each rising edge of the synchronized serial clock, the 14-bit shift register takes the synchronized serial data bit into bit 0 and moves every other bit one place toward bit 13. `shift_out` shows bit 13, which is the bit shifted in 14 rising edges earlier.
- R2: Fields leave the shift register in this order. Bits 13..11 form the test select, sent first with its bit 2 leading. Bits 10..9 form the output divider code, with its bit 1 leading. Bits 8..0 form the feedback divider, with bit 8 leading and bit 0 sent last.
- R3: While the parallel strobe is high and the serial load strobe is high, `cfg_m`, `cfg_n` and `cfg_t` follow the shift register contents. When the serial load strobe falls, the last value is kept, and later shifts leave the outputs unchanged.
- R4: While the parallel strobe is low, `cfg_m` and `cfg_n` follow `par_m` and `par_n`. The value present when the strobe rises is kept, and later pin changes have no effect.
- R5: `cfg_t` is 000 whenever the parallel strobe is low, including when a nonzero test select was loaded serially before.
- R6: A serial load pulse has no effect while the parallel strobe is low.
- R7: `m_out_of_range` is 1 exactly when `cfg_m` is below 200 or above 400.
- R8: While reset is asserted, `cfg_m`, `cfg_n`, `cfg_t` and `shift_out` are all zero, so `m_out_of_range` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it must be much faster than the strobes |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data bit |
| ser_ld | input | 1 | Serial load strobe: transparent while high, holds on the falling edge |
| par_ld | input | 1 | Parallel load strobe: transparent while low, holds on the rising edge |
| par_m | input | 9 | Parallel feedback divider pins |
| par_n | input | 2 | Parallel output divider code pins |
| cfg_m | output | 9 | Held feedback divider value |
| cfg_n | output | 2 | Held output divider code |
| cfg_t | output | 3 | Held test select |
| shift_out | output | 1 | Most significant bit of the shift register |
| m_out_of_range | output | 1 | Held feedback divider lies outside 200..400 |

## Verification
The hardest case to reach is a conflict between the two routes. A nonzero test select must first be committed serially. The parallel strobe then has to drop and force it to zero, and a serial load pulse arriving during that window must change nothing. The bench first commits a serial word with a nonzero test field. It then lowers the parallel strobe, pulses the serial load, and raises the parallel strobe again, checking the outputs at each step. A second hard point is the transparent window itself: the bench shifts single bits with the serial load held high and predicts each shifted word arithmetically.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
   localparam int unsigned DEF_M_W   = 9;
   localparam int unsigned DEF_N_W   = 2;
   localparam int unsigned DEF_T_W   = 3;
   localparam int unsigned DEF_M_LO  = 200;
   localparam int unsigned DEF_M_HI  = 400;
   localparam int unsigned DEF_SYNC  = 2;

   // number of control lines that share the synchronizer besides the pins
   localparam int unsigned CTRL_LINES = 4;

   typedef enum logic [1:0] {
      SRC_PINS   = 2'd0,
      SRC_SHIFT  = 2'd1,
      SRC_HOLD   = 2'd2
   } cfg_src_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("cfg_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("cfg_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= '0;
      end else begin
         pipe[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            pipe[s] <= pipe[s-1];
         end
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfg_shreg.sv
module cfg_shreg #(
   parameter int unsigned W = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sclk_s,
   input  logic         sdat_s,
   output logic [W-1:0] word,
   output logic         msb
);
   generate
      if (W < 2) begin : g_bad_width
         $error("cfg_shreg: W must be at least 2");
      end
   endgenerate

   logic sclk_q;
   logic sclk_rise;

   assign sclk_rise = sclk_s & ~sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         word   <= '0;
      end else begin
         sclk_q <= sclk_s;
         if (sclk_rise) begin
            word <= {word[W-2:0], sdat_s};
         end
      end
   end

   assign msb = word[W-1];
endmodule

// File: rtl/cfg_hold.sv
module cfg_hold
   import cfg_pkg::*;
#(
   parameter int unsigned M_W = 9,
   parameter int unsigned N_W = 2,
   parameter int unsigned T_W = 3,
   localparam int unsigned SR_W = M_W + N_W + T_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            par_ld_s,
   input  logic            ser_ld_s,
   input  logic [M_W-1:0]  pin_m,
   input  logic [N_W-1:0]  pin_n,
   input  logic [SR_W-1:0] sr_word,
   output logic [M_W-1:0]  m_q,
   output logic [N_W-1:0]  n_q,
   output logic [T_W-1:0]  t_q
);
   cfg_src_e src;

   // parallel strobe low wins over everything
   always_comb begin
      if (!par_ld_s)     src = SRC_PINS;
      else if (ser_ld_s) src = SRC_SHIFT;
      else               src = SRC_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_q <= '0;
         n_q <= '0;
         t_q <= '0;
      end else begin
         case (src)
            SRC_PINS: begin
               m_q <= pin_m;
               n_q <= pin_n;
               t_q <= '0;
            end
            SRC_SHIFT: begin
               t_q <= sr_word[SR_W-1 -: T_W];
               n_q <= sr_word[M_W +: N_W];
               m_q <= sr_word[M_W-1:0];
            end
            default: begin
               m_q <= m_q;
               n_q <= n_q;
               t_q <= t_q;
            end
         endcase
      end
   end
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
   import cfg_pkg::*;
#(
   parameter int unsigned M_W         = DEF_M_W,
   parameter int unsigned N_W         = DEF_N_W,
   parameter int unsigned T_W         = DEF_T_W,
   parameter int unsigned SYNC_STAGES = DEF_SYNC,
   parameter int unsigned M_LO        = DEF_M_LO,
   parameter int unsigned M_HI        = DEF_M_HI,
   parameter bit          RANGE_CHECK = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ser_clk,
   input  logic           ser_dat,
   input  logic           ser_ld,
   input  logic           par_ld,
   input  logic [M_W-1:0] par_m,
   input  logic [N_W-1:0] par_n,
   output logic [M_W-1:0] cfg_m,
   output logic [N_W-1:0] cfg_n,
   output logic [T_W-1:0] cfg_t,
   output logic           shift_out,
   output logic           m_out_of_range
);
   localparam int unsigned SR_W   = M_W + N_W + T_W;
   localparam int unsigned SYNC_W = CTRL_LINES + M_W + N_W;

   generate
      if (M_HI >= (1 << M_W)) begin : g_bad_hi
         $error("synth_cfg_loader: M_HI does not fit in M_W bits");
      end
      if (M_LO > M_HI) begin : g_bad_window
         $error("synth_cfg_loader: M_LO above M_HI");
      end
   endgenerate

   logic [SYNC_W-1:0] sync_d;
   logic [SYNC_W-1:0] sync_q;
   logic              ser_clk_s;
   logic              ser_dat_s;
   logic              ser_ld_s;
   logic              par_ld_s;
   logic [M_W-1:0]    pin_m_s;
   logic [N_W-1:0]    pin_n_s;
   logic [SR_W-1:0]   sr_word;

   // pins share the control synchronizer so they stay aligned with the strobes
   assign sync_d = {ser_clk, ser_dat, ser_ld, par_ld, par_m, par_n};

   cfg_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sync_d),
      .q     (sync_q)
   );

   assign {ser_clk_s, ser_dat_s, ser_ld_s, par_ld_s, pin_m_s, pin_n_s} = sync_q;

   cfg_shreg #(.W(SR_W)) u_shreg (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_s (ser_clk_s),
      .sdat_s (ser_dat_s),
      .word   (sr_word),
      .msb    (shift_out)
   );

   cfg_hold #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .par_ld_s (par_ld_s),
      .ser_ld_s (ser_ld_s),
      .pin_m    (pin_m_s),
      .pin_n    (pin_n_s),
      .sr_word  (sr_word),
      .m_q      (cfg_m),
      .n_q      (cfg_n),
      .t_q      (cfg_t)
   );

   generate
      if (RANGE_CHECK) begin : g_range
         localparam logic [M_W-1:0] LO_V = M_W'(M_LO);
         localparam logic [M_W-1:0] HI_V = M_W'(M_HI);
         assign m_out_of_range = (cfg_m < LO_V) || (cfg_m > HI_V);
      end else begin : g_no_range
         assign m_out_of_range = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
   parameter int unsigned M_W = 9,
   parameter int unsigned N_W = 2,
   parameter int unsigned T_W = 3,
   localparam int unsigned SR_W = M_W + N_W + T_W
) (
   input logic            clk,
   input logic            rst_n,
   input logic            par_ld_s,
   input logic            ser_ld_s,
   input logic            ser_clk_s,
   input logic            ser_dat_s,
   input logic [M_W-1:0]  pin_m_s,
   input logic [N_W-1:0]  pin_n_s,
   input logic [SR_W-1:0] sr_word,
   input logic [M_W-1:0]  cfg_m,
   input logic [N_W-1:0]  cfg_n,
   input logic [T_W-1:0]  cfg_t
);
   // R5: test select cleared while the parallel strobe is low
   a_r5_t_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      !par_ld_s |=> (cfg_t == '0));

   // R4: divider outputs track the synchronized pins while the strobe is low
   a_r4_pins_pass: assert property (@(posedge clk) disable iff (!rst_n)
      !par_ld_s |=> (cfg_m == $past(pin_m_s) && cfg_n == $past(pin_n_s)));

   // R3: serial transparency with the parallel strobe high
   a_r3_shift_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (par_ld_s && ser_ld_s) |=> ({cfg_t, cfg_n, cfg_m} == $past(sr_word)));

   // R3 and R4: no strobe open means the outputs hold
   a_r3_hold_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (par_ld_s && !ser_ld_s) |=> $stable({cfg_t, cfg_n, cfg_m}));

   // R1: the shift register moves only on a synchronized clock rise
   a_r1_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk_s && !$past(ser_clk_s)) |=>
         (sr_word == {$past(sr_word[SR_W-2:0]), $past(ser_dat_s)}));

   a_r1_no_rise_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !(ser_clk_s && !$past(ser_clk_s)) |=> $stable(sr_word));
endmodule

bind synth_cfg_loader cfg_loader_chk #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .par_ld_s  (par_ld_s),
   .ser_ld_s  (ser_ld_s),
   .ser_clk_s (ser_clk_s),
   .ser_dat_s (ser_dat_s),
   .pin_m_s   (pin_m_s),
   .pin_n_s   (pin_n_s),
   .sr_word   (sr_word),
   .cfg_m     (cfg_m),
   .cfg_n     (cfg_n),
   .cfg_t     (cfg_t)
);

// File: tb/synth_cfg_loader_tb.sv
module synth_cfg_loader_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_clk = 1'b0;
   logic       ser_dat = 1'b0;
   logic       ser_ld = 1'b0;
   logic       par_ld = 1'b0;
   logic [8:0] par_m = '0;
   logic [1:0] par_n = '0;
   logic [8:0] cfg_m;
   logic [1:0] cfg_n;
   logic [2:0] cfg_t;
   logic       shift_out;
   logic       m_out_of_range;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [13:0] sr_model = '0;

   always #5 clk = ~clk;

   synth_cfg_loader u_dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ser_ld(ser_ld), .par_ld(par_ld), .par_m(par_m), .par_n(par_n),
      .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t),
      .shift_out(shift_out), .m_out_of_range(m_out_of_range)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic shift_bit(input logic b);
      ser_dat = b;
      cyc(4);
      ser_clk = 1'b1;
      cyc(4);
      ser_clk = 1'b0;
      cyc(1);
      sr_model = {sr_model[12:0], b};
   endtask

   task automatic shift_word(input logic [13:0] w);
      for (int i = 13; i >= 0; i--) shift_bit(w[i]);
   endtask

   task automatic ser_pulse();
      ser_ld = 1'b1;
      cyc(6);
      ser_ld = 1'b0;
      cyc(6);
   endtask

   function automatic logic flag_of(input logic [8:0] m);
      return (m < 9'd200) || (m > 9'd400);
   endfunction

   task automatic chk_word(input string req, input logic [13:0] w);
      chk(req, {29'd0, cfg_t}, {29'd0, w[13:11]});
      chk(req, {30'd0, cfg_n}, {30'd0, w[10:9]});
      chk(req, {23'd0, cfg_m}, {23'd0, w[8:0]});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [13:0] w;
      logic [13:0] held;
      logic [31:0] lcg;

      // R8: reset state
      cyc(3);
      chk("R8 m", {23'd0, cfg_m}, 32'd0);
      chk("R8 n", {30'd0, cfg_n}, 32'd0);
      chk("R8 t", {29'd0, cfg_t}, 32'd0);
      chk("R8 shift_out", {31'd0, shift_out}, 32'd0);
      chk("R8 flag", {31'd0, m_out_of_range}, 32'd1);
      rst_n = 1'b1;
      cyc(2);

      // R4, R5, R7: exhaustive parallel sweep with the strobe low
      for (int m = 0; m < 512; m++) begin
         for (int n = 0; n < 4; n++) begin
            par_m = 9'(m);
            par_n = 2'(n);
            cyc(5);
            chk("R4 m", {23'd0, cfg_m}, 32'(m));
            chk("R4 n", {30'd0, cfg_n}, 32'(n));
            chk("R5 t", {29'd0, cfg_t}, 32'd0);
            chk("R7 flag", {31'd0, m_out_of_range}, {31'd0, flag_of(9'(m))});
         end
      end

      // R4: value at the rising strobe is kept, later pins ignored
      par_m = 9'd262; par_n = 2'd1;
      cyc(5);
      par_ld = 1'b1;
      cyc(6);
      par_m = 9'd17; par_n = 2'd2;
      cyc(8);
      chk("R4 hold m", {23'd0, cfg_m}, 32'd262);
      chk("R4 hold n", {30'd0, cfg_n}, 32'd1);
      chk("R7 hold flag", {31'd0, m_out_of_range}, 32'd0);

      // R1, R2, R3: serial words computed from an LCG
      lcg = 32'h1234_5677;
      for (int k = 0; k < 40; k++) begin
         lcg = lcg * 32'd1103515245 + 32'd12345;
         w = lcg[25:12];
         shift_word(w);
         chk("R1 shift_out", {31'd0, shift_out}, {31'd0, w[13]});
         ser_pulse();
         chk_word("R2 R3 load", w);
         chk("R7 serial flag", {31'd0, m_out_of_range}, {31'd0, flag_of(w[8:0])});
      end

      // R3: shifting after the falling edge leaves outputs unchanged
      held = sr_model;
      shift_word(14'h0ABC);
      chk_word("R3 hold after fall", held);

      // R3: transparent while the serial strobe is high
      ser_ld = 1'b1;
      cyc(6);
      chk_word("R3 transparent", sr_model);
      shift_bit(1'b1);
      cyc(4);
      chk_word("R3 transparent step1", sr_model);
      shift_bit(1'b0);
      cyc(4);
      chk_word("R3 transparent step2", sr_model);
      ser_ld = 1'b0;
      cyc(6);
      held = sr_model;
      shift_bit(1'b1);
      cyc(4);
      chk_word("R3 closed", held);

      // R5, R6: nonzero test select, then parallel override
      w = {3'b110, 2'b10, 9'd300};
      shift_word(w);
      ser_pulse();
      chk_word("R2 test field", w);
      par_m = 9'd150; par_n = 2'd3;
      par_ld = 1'b0;
      cyc(6);
      chk("R5 forced t", {29'd0, cfg_t}, 32'd0);
      chk("R4 override m", {23'd0, cfg_m}, 32'd150);
      ser_pulse();
      chk("R6 ignored t", {29'd0, cfg_t}, 32'd0);
      chk("R6 ignored m", {23'd0, cfg_m}, 32'd150);
      chk("R6 ignored n", {30'd0, cfg_n}, 32'd3);
      chk("R7 low m flag", {31'd0, m_out_of_range}, 32'd1);
      par_ld = 1'b1;
      cyc(6);
      chk("R4 rise keeps m", {23'd0, cfg_m}, 32'd150);
      chk("R5 t stays zero", {29'd0, cfg_t}, 32'd0);

      // R7: window edges through the serial path
      shift_word({3'd0, 2'd0, 9'd200}); ser_pulse();
      chk("R7 edge 200", {31'd0, m_out_of_range}, 32'd0);
      shift_word({3'd0, 2'd0, 9'd199}); ser_pulse();
      chk("R7 edge 199", {31'd0, m_out_of_range}, 32'd1);
      shift_word({3'd0, 2'd0, 9'd400}); ser_pulse();
      chk("R7 edge 400", {31'd0, m_out_of_range}, 32'd0);
      shift_word({3'd0, 2'd0, 9'd401}); ser_pulse();
      chk("R7 edge 401", {31'd0, m_out_of_range}, 32'd1);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule